// File: doc/BRIEF.md
# PLL Feedback Multiplier Code Converter

This block converts a PLL feedback multiplier between its plain binary value (1 to 32768) and the 17-bit scrambled code that the PLL loop hardware decodes. The code is the state of a 15-bit shift-register sequence. Encoding starts that sequence from a fixed seed and advances it once for every value from the multiplier up to the top of the range. Decoding runs the inverse step and counts down until the seed comes back. The two smallest multipliers have dedicated codes that bypass the sequence.

On an encode, the block also derives the two loop-bandwidth selectors from the binary multiplier. It packs them with the code into a single 32-bit multiplier word that is ready to be written to the PLL. The proportional selector is called P and the integral selector is called I. One operation runs at a time under a start/busy/done handshake. The sequence moves one step per clock, so latency depends on the value: a multiplier near the top of the range finishes in a few cycles, and a small one takes about 32 thousand cycles.

Top module: `pll_mcode_conv`

## Requirements
- R1: Encoding multiplier 0 gives code 0, multiplier 1 gives code 0x18003 and multiplier 2 gives code 0x10003.
- R2: Encoding any other multiplier m ≤ 32768 starts from 0x4000 and applies x = (((x ^ (x>>1)) & 1) << 14) | ((x >> 1) & 0xFFFF) once for each value from m through 32768 inclusive. For example, m = 32768 gives 0x2000.
- R3: Decoding code 0x18003 returns 1 and decoding code 0x10003 returns 2.
- R4: Decoding any other code loads a counter with 32769. Each cycle the block checks whether x equals 0x4000 or the counter is 0; if neither holds, it applies x = ((x ^ (x>>14)) & 1) | ((x << 1) & 0x7FFF) and decrements the counter. The result is the counter, so code 0x4000 decodes to 32769.
- R5: For every multiplier 1..32768, decoding the code that the encoder produced returns the original multiplier.
- R6: The encode result word `mdiv_out` holds the code in bits 16:0, the P selector in bits 21:17, the I selector in bits 27:22, and zeros in bits 31:28.
- R7: The P selector is (m >> 1) + 1 for m < 60 and 31 otherwise.
- R8: The I selector is 1 for m > 16384, 2 for 8192 < m ≤ 16384, 4 for 2048 < m ≤ 8192 and 8 for 501 ≤ m ≤ 2048.
- R9: For 60 ≤ m ≤ 500, with t = floor(1024 / (m + 9)), the I selector is 4·t when t·(m+9) ≠ 1024 and 4·(t+1) when it equals 1024. For m < 60 it is (m & 0x3C) + 4.
- R10: An encode request with a multiplier above 32768 raises `done` and `error` one cycle after the start edge and clears `mdiv_out` to 0. The next accepted start clears `error`.
- R11: `start` is taken only while `busy` is low, and a start during `busy` has no effect. `done` is a single-cycle pulse in the cycle in which `busy` falls.
- R12: A decode leaves `mdiv_out` unchanged, and an encode leaves `msel_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_dec | input | 1 | 0 = encode multiplier, 1 = decode code |
| msel_in | input | 16 | Binary multiplier to encode |
| code_in | input | 17 | Scrambled code to decode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request was out of range |
| msel_out | output | 16 | Decoded multiplier |
| mdiv_out | output | 32 | Packed code plus P and I selectors |

## Verification
The stimulus table walks the multiplier through every bandwidth band: the special values 0, 1 and 2, values just above the 16384 and 8192 limits, the 2048 edge, the exact-divisor case 247 and the inexact case 100. A wrong comparison or rounding choice therefore changes a visible selector field. Values at the top of the range (32768, 32767, 32000, 16385) are also decoded again, which separates a correct inverse step and counter from an off-by-one in either direction. Directed cases cover the 0x4000 code (zero steps, result 32769), out-of-range multipliers, a start issued mid-operation, and that each operation kind leaves the other result untouched.

// File: rtl/pll_mcode_pkg.sv
package pll_mcode_pkg;
  localparam int CODE_W   = 17;
  localparam int LFSR_W   = 15;
  localparam int SELP_W   = 5;
  localparam int SELI_W   = 6;
  localparam int WORD_W   = 32;
  localparam int SELP_LSB = 17;
  localparam int SELI_LSB = 22;

  localparam logic [CODE_W-1:0] SEED    = 17'h04000;
  localparam logic [CODE_W-1:0] CODE_M1 = 17'h18003;
  localparam logic [CODE_W-1:0] CODE_M2 = 17'h10003;

  typedef enum logic {OP_ENC = 1'b0, OP_DEC = 1'b1} op_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} top_st_e;

  // forward step: shift right, feedback of the two low bits into bit 14
  function automatic logic [CODE_W-1:0] fwd_step(input logic [CODE_W-1:0] x);
    logic [CODE_W-1:0] r;
    r = {1'b0, x[CODE_W-1:1]};
    r[LFSR_W-1] = r[LFSR_W-1] | (x[0] ^ x[1]);
    return r;
  endfunction

  // inverse step: shift left within 15 bits, feedback into bit 0
  function automatic logic [CODE_W-1:0] rev_step(input logic [CODE_W-1:0] x);
    return {{(CODE_W-LFSR_W){1'b0}}, x[LFSR_W-2:0], x[0] ^ x[LFSR_W-1]};
  endfunction
endpackage

// File: rtl/pll_div_iter.sv
module pll_div_iter #(
  parameter int NUM_W = 11,
  parameter int DEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quot,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             busy_q, busy_d, fin_q, fin_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    fin_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(NUM_W);
        quo_d  = num;
        rem_d  = '0;
        den_d  = den;
      end
    end else begin
      rem_d = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_d = {quo_q[NUM_W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;
  assign rem  = rem_q;

  // partial remainder never reaches the divisor (R9)
  assert_rem_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < den_q));
  assert_den_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (den_q != '0));
endmodule

// File: rtl/pll_bw_sel.sv
module pll_bw_sel
  import pll_mcode_pkg::*;
#(
  parameter int MSEL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MSEL_W-1:0] msel_in,
  output logic              fin,
  output logic [SELP_W-1:0] selp,
  output logic [SELI_W-1:0] seli
);
  localparam int NUM_W = 11;
  localparam int DEN_W = 10;
  localparam int T_W   = SELI_W - 2;
  localparam logic [NUM_W-1:0] DIVIDEND = NUM_W'(1024);

  logic              wait_q, wait_d, fin_q, fin_d;
  logic [SELP_W-1:0] selp_q, selp_d;
  logic [SELI_W-1:0] seli_q, seli_d;
  logic              mid, div_start, div_fin;
  logic [NUM_W-1:0]  div_quot;
  logic [DEN_W-1:0]  div_rem, div_den;
  logic [T_W-1:0]    t_val;

  assign mid       = (msel_in >= MSEL_W'(60)) && (msel_in <= MSEL_W'(500));
  assign div_start = start && !wait_q && mid;
  assign div_den   = msel_in[DEN_W-1:0] + DEN_W'(9);
  assign t_val     = div_quot[T_W-1:0];

  pll_div_iter #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (DIVIDEND),
    .den   (div_den),
    .fin   (div_fin),
    .quot  (div_quot),
    .rem   (div_rem)
  );

  always_comb begin
    wait_d = wait_q;
    selp_d = selp_q;
    seli_d = seli_q;
    fin_d  = 1'b0;
    if (!wait_q) begin
      if (start) begin
        if (msel_in < MSEL_W'(60)) selp_d = SELP_W'(msel_in[5:1]) + SELP_W'(1);
        else                       selp_d = SELP_W'(31);
        if (mid) begin
          wait_d = 1'b1;
        end else begin
          fin_d = 1'b1;
          if      (msel_in > MSEL_W'(16384)) seli_d = SELI_W'(1);
          else if (msel_in > MSEL_W'(8192))  seli_d = SELI_W'(2);
          else if (msel_in > MSEL_W'(2048))  seli_d = SELI_W'(4);
          else if (msel_in > MSEL_W'(500))   seli_d = SELI_W'(8);
          else                               seli_d = {msel_in[5:2], 2'b00} + SELI_W'(4);
        end
      end
    end else if (div_fin) begin
      wait_d = 1'b0;
      fin_d  = 1'b1;
      if (div_rem != '0) seli_d = {t_val, 2'b00};
      else               seli_d = {t_val + T_W'(1), 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      fin_q  <= 1'b0;
      selp_q <= '0;
      seli_q <= '0;
    end else begin
      wait_q <= wait_d;
      fin_q  <= fin_d;
      selp_q <= selp_d;
      seli_q <= seli_d;
    end
  end

  assign fin  = fin_q;
  assign selp = selp_q;
  assign seli = seli_q;

  // quotient for the mid band fits the selector field (R9)
  assert_quot_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && div_fin) |-> (div_quot < NUM_W'(15)));
  assert_sel_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> ((seli_q != '0) && (selp_q != '0)));
endmodule

// File: rtl/pll_mcode_walk.sv
module pll_mcode_walk
  import pll_mcode_pkg::*;
#(
  parameter int MSEL_W   = 16,
  parameter int MSEL_MAX = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_dec,
  input  logic [MSEL_W-1:0] msel_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              fin,
  output logic [CODE_W-1:0] code_out,
  output logic [MSEL_W-1:0] msel_out
);
  localparam logic [MSEL_W-1:0] LIM = MSEL_W'(MSEL_MAX);
  localparam logic [MSEL_W-1:0] TOP = MSEL_W'(MSEL_MAX + 1);

  logic              run_q, run_d, dec_q, dec_d, fin_q, fin_d;
  logic [CODE_W-1:0] x_q, x_d;
  logic [MSEL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    dec_d = dec_q;
    x_d   = x_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (!run_q) begin
      if (start) begin
        dec_d = dir_dec;
        if (!dir_dec) begin
          cnt_d = msel_in;
          if (msel_in == MSEL_W'(0)) begin
            x_d = '0; fin_d = 1'b1;
          end else if (msel_in == MSEL_W'(1)) begin
            x_d = CODE_M1; fin_d = 1'b1;
          end else if (msel_in == MSEL_W'(2)) begin
            x_d = CODE_M2; fin_d = 1'b1;
          end else begin
            x_d = SEED; run_d = 1'b1;
          end
        end else begin
          x_d = code_in;
          if (code_in == CODE_M1) begin
            cnt_d = MSEL_W'(1); fin_d = 1'b1;
          end else if (code_in == CODE_M2) begin
            cnt_d = MSEL_W'(2); fin_d = 1'b1;
          end else begin
            cnt_d = TOP; run_d = 1'b1;
          end
        end
      end
    end else if (!dec_q) begin
      if (cnt_q > LIM) begin
        run_d = 1'b0; fin_d = 1'b1;
      end else begin
        x_d   = fwd_step(x_q);
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if ((x_q == SEED) || (cnt_q == '0)) begin
        run_d = 1'b0; fin_d = 1'b1;
      end else begin
        x_d   = rev_step(x_q);
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dec_q <= 1'b0;
      fin_q <= 1'b0;
      x_q   <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      dec_q <= dec_d;
      fin_q <= fin_d;
      x_q   <= x_d;
      cnt_q <= cnt_d;
    end
  end

  assign fin      = fin_q;
  assign code_out = x_q;
  assign msel_out = cnt_q;

  // encode walk never passes one beyond the top multiplier (R2)
  assert_enc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !dec_q) |-> (cnt_q <= TOP));
  // encode walk stays inside the 15-bit sequence (R2)
  assert_enc_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !dec_q) |-> (x_q[CODE_W-1:LFSR_W] == '0));
  // after the first inverse step the state is 15 bits wide (R4)
  assert_dec_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && dec_q && (cnt_q != TOP)) |-> (x_q[CODE_W-1:LFSR_W] == '0));
endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
  import pll_mcode_pkg::*;
#(
  parameter int MSEL_W   = 16,
  parameter int MSEL_MAX = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_dec,
  input  logic [MSEL_W-1:0] msel_in,
  input  logic [16:0]       code_in,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [MSEL_W-1:0] msel_out,
  output logic [31:0]       mdiv_out
);
  localparam int PAD_W = WORD_W - SELI_LSB - SELI_W;
  localparam logic [MSEL_W-1:0] LIM = MSEL_W'(MSEL_MAX);

  top_st_e           st_q, st_d;
  op_e               op_q, op_d;
  logic              wg_q, wg_d, bg_q, bg_d;
  logic              done_q, done_d, err_q, err_d;
  logic [MSEL_W-1:0] msel_q, msel_d;
  logic [WORD_W-1:0] mdiv_q, mdiv_d;

  logic              idle, over, bad_req, launch;
  logic              walk_fin, bw_fin;
  logic [CODE_W-1:0] walk_code;
  logic [MSEL_W-1:0] walk_msel;
  logic [SELP_W-1:0] bw_selp;
  logic [SELI_W-1:0] bw_seli;
  logic              wg_n, bg_n;

  assign idle    = (st_q == ST_IDLE);
  assign over    = (msel_in > LIM);
  assign bad_req = start && idle && !op_dec && over;
  assign launch  = start && idle && !(!op_dec && over);

  pll_mcode_walk #(.MSEL_W(MSEL_W), .MSEL_MAX(MSEL_MAX)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .dir_dec  (op_dec),
    .msel_in  (msel_in),
    .code_in  (code_in),
    .fin      (walk_fin),
    .code_out (walk_code),
    .msel_out (walk_msel)
  );

  pll_bw_sel #(.MSEL_W(MSEL_W)) u_bw (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch && !op_dec),
    .msel_in (msel_in),
    .fin     (bw_fin),
    .selp    (bw_selp),
    .seli    (bw_seli)
  );

  assign wg_n = wg_q | walk_fin;
  assign bg_n = bg_q | bw_fin;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    wg_d   = wg_q;
    bg_d   = bg_q;
    done_d = 1'b0;
    err_d  = err_q;
    msel_d = msel_q;
    mdiv_d = mdiv_q;
    if (idle) begin
      if (bad_req) begin
        done_d = 1'b1;
        err_d  = 1'b1;
        mdiv_d = '0;
      end else if (launch) begin
        st_d  = ST_WAIT;
        op_d  = op_dec ? OP_DEC : OP_ENC;
        wg_d  = 1'b0;
        bg_d  = op_dec;
        err_d = 1'b0;
      end
    end else begin
      wg_d = wg_n;
      bg_d = bg_n;
      if (wg_n && bg_n) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        if (op_q == OP_DEC) msel_d = walk_msel;
        else                mdiv_d = {{PAD_W{1'b0}}, bw_seli, bw_selp, walk_code};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_ENC;
      wg_q   <= 1'b0;
      bg_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      msel_q <= '0;
      mdiv_q <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      wg_q   <= wg_d;
      bg_q   <= bg_d;
      done_q <= done_d;
      err_q  <= err_d;
      msel_q <= msel_d;
      mdiv_q <= mdiv_d;
    end
  end

  assign busy     = !idle;
  assign done     = done_q;
  assign error    = err_q;
  assign msel_out = msel_q;
  assign mdiv_out = mdiv_q;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_over_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_dec && (msel_in > LIM)) |=> (done && error && (mdiv_out == '0)));
  assert_dec_special_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_dec && (code_in == CODE_M2)) |=> ##1 (done && (msel_out == MSEL_W'(2))));
  assert_word_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mdiv_out[WORD_W-1:SELI_LSB+SELI_W] == '0));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(mdiv_out) && $stable(msel_out)));
endmodule

// File: tb/pll_mcode_conv_test.sv
module pll_mcode_conv_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_dec = 1'b0;
  logic [15:0] msel_in = '0;
  logic [16:0] code_in = '0;
  logic        busy, done, error;
  logic [15:0] msel_out;
  logic [31:0] mdiv_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pll_mcode_conv uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_dec   (op_dec),
    .msel_in  (msel_in),
    .code_in  (code_in),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .msel_out (msel_out),
    .mdiv_out (mdiv_out)
  );

  localparam int NV = 11;
  localparam int VM [NV] = '{0, 1, 2, 32768, 32767, 32000, 16385, 8193, 2048, 247, 100};
  localparam int VP [NV] = '{1, 1, 2, 31,    31,    31,    31,    31,   31,   31,  31};
  localparam int VI [NV] = '{4, 4, 4, 1,     1,     1,     1,     2,    8,    20,  36};
  localparam bit VR [NV] = '{0, 1, 1, 1,     1,     1,     1,     0,    0,    0,   0};

  function automatic int enc_model(input int m);
    int x;
    if (m == 0) return 0;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = m; i <= 32768; i++)
      x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hFFFF);
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // drive one request and wait for its done pulse; returns cycles to done
  task automatic run_op(input bit dec, input int m, input int code, output int lat);
    @(negedge clk);
    op_dec  = dec;
    msel_in = m[15:0];
    code_in = code[16:0];
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40000) begin
      @(negedge clk);
      lat++;
    end
    chk(done, "R11 done seen", int'(done), 1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!done, "R11 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 199000, 0);
    summary();
  end

  initial begin
    int lat, code, last_msel;
    logic [31:0] last_word;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !error, "R11 reset flags", {busy, done, error}, 0);
    chk(mdiv_out == 0 && msel_out == 0, "R6 reset outputs", mdiv_out, 0);
    rst_n = 1'b1;
    last_msel = 0;
    last_word = '0;

    for (int k = 0; k < NV; k++) begin
      code = enc_model(VM[k]);
      run_op(1'b0, VM[k], 0, lat);
      chk(mdiv_out[16:0] == code[16:0], (VM[k] <= 2) ? "R1 code" : "R2 code", mdiv_out[16:0], code);
      chk(mdiv_out[21:17] == VP[k][4:0], "R7 P selector", mdiv_out[21:17], VP[k]);
      chk(mdiv_out[27:22] == VI[k][5:0], (VM[k] < 60 || VM[k] > 500) ? "R8 I selector" : "R9 I selector",
          mdiv_out[27:22], VI[k]);
      chk(mdiv_out[31:28] == 0, "R6 upper bits", mdiv_out[31:28], 0);
      chk(int'(msel_out) == last_msel, "R12 encode keeps msel_out", msel_out, last_msel);
      chk(!error, "R10 error clear", int'(error), 0);
      last_word = mdiv_out;
      after_done();
      if (VR[k]) begin
        run_op(1'b1, 0, code, lat);
        chk(int'(msel_out) == VM[k], (VM[k] <= 2) ? "R3 decode special" : "R5 round trip",
            msel_out, VM[k]);
        chk(mdiv_out == last_word, "R12 decode keeps mdiv_out", mdiv_out, last_word);
        last_msel = int'(msel_out);
        after_done();
      end
    end

    // seed code: zero inverse steps, counter untouched
    run_op(1'b1, 0, 'h4000, lat);
    chk(int'(msel_out) == 32769, "R4 seed code", msel_out, 32769);
    run_op(1'b1, 0, 'h2000, lat);
    chk(int'(msel_out) == 32768, "R4 one step", msel_out, 32768);
    last_msel = 32768;

    // out-of-range multipliers
    run_op(1'b0, 32769, 0, lat);
    chk(error && lat == 1, "R10 error one cycle", {error, lat[15:0]}, 1);
    chk(mdiv_out == 0, "R10 word cleared", mdiv_out, 0);
    chk(int'(msel_out) == last_msel, "R12 error keeps msel_out", msel_out, last_msel);
    after_done();
    run_op(1'b0, 65535, 0, lat);
    chk(error, "R10 error at 65535", int'(error), 1);

    // start while busy is ignored
    code = enc_model(32000);
    @(negedge clk);
    op_dec = 1'b0; msel_in = 16'd32000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R11 busy after start", int'(busy), 1);
    chk(!error, "R10 error cleared by start", int'(error), 0);
    repeat (10) @(negedge clk);
    msel_in = 16'd32768; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40000) begin
      @(negedge clk);
      lat++;
    end
    chk(mdiv_out[16:0] == code[16:0], "R11 busy start ignored", mdiv_out[16:0], code);
    repeat (5) @(negedge clk);
    chk(!done && !busy, "R11 no second run", {done, busy}, 0);

    summary();
  end
endmodule